// File: doc/BRIEF.md
# Byte-Lane Parity Guard

This block sits between a 32-bit requester and a memory array built from four 8-bit data lanes. It computes a parity bit per lane on every write, checks those bits on every read, and keeps a sticky record of which lanes have failed. Each read completes two cycles after acceptance. Each single write completes one cycle after acceptance. A partial write in read-modify-write mode completes three cycles after acceptance.

The block has two placement modes, selected by `cfg_rmw_mode`. In lane mode (0), every data lane has its own parity bit. That bit is written under the same enable as its data byte, and the parity-lane enable `mem_be[4]` stays low. In shared mode (1), all four parity bits live in a separate parity byte that has its own enable, `mem_be[4]`. Shared mode has one consequence for writes: a write that covers fewer than all four lanes cannot update the shared parity byte on its own. The block therefore reads the whole word, merges in the new bytes, recomputes all four parity bits and writes the full word back. Full-width writes and all reads stay single accesses.

Polarity is selected by `cfg_odd_par` and applies to every lane. Software sees the failed lanes in a 16-bit status view and clears them by writing ones.

Top module: `bytelane_parity_unit`

## Requirements
- R1: In lane mode, a write is one memory access in its acceptance cycle. That access drives `mem_be[3:0]` = `req_be`, `mem_be[4]` = 0, `mem_wdata` = `req_wdata`, and `mem_wpar[i]` for each lane i. `rsp_valid` pulses one cycle after acceptance.
- R2: With `cfg_odd_par` = 0, the parity bit of a byte is the XOR of its eight bits (even parity). With `cfg_odd_par` = 1, it is the inverse (odd parity).
- R3: In shared mode, a write with `req_be` = 4'hF is one write access with `mem_be` = 5'h1F and no read. `rsp_valid` pulses one cycle after acceptance.
- R4: In shared mode, a write with any other `req_be` proceeds in three steps. First, a read with `mem_be` = 5'h1F is issued in the acceptance cycle. Second, a write-back with `mem_be` = 5'h1F is issued two cycles later; it carries enabled lanes from `req_wdata`, the other lanes from the read data, and freshly computed parity for all four lanes. Third, `rsp_valid` pulses three cycles after acceptance.
- R5: A read is one access in its acceptance cycle, with `mem_be` = {`cfg_rmw_mode`, `req_be`}. `mem_rdata` and `mem_rpar` are expected one cycle after the access. `rsp_valid` and `rsp_rdata` appear two cycles after acceptance.
- R6: A checked lane whose stored parity bit differs from the recomputed one sets status bit 8+i for lane i. Only failing lanes are set. During a read, the checked lanes are the requested lanes. During the read phase of R4, all four lanes are checked, and the errors found there are recorded.
- R7: A lane not requested by a read never sets its status bit, even if its stored parity is wrong.
- R8: Status bits stay set until `stat_clr[i]` = 1 clears lane i. A zero in `stat_clr` has no effect. If a new error and a clear reach the same bit in the same cycle, the bit stays set.
- R9: `par_err_pulse` is high for exactly one cycle for each check that finds at least one error. It is high in the same cycle that the new status bits first read as 1.
- R10: `stat_rdata` carries lane i in bit 8+i. Bits 7:0 and 15:12 always read 0.
- R11: After a synchronous reset, the outputs are as follows: `req_ready` = 1, `rsp_valid` = 0, `par_err_pulse` = 0, `stat_rdata` = 0, and `mem_en` = 0 while no request is presented.
- R12: `req_ready` is low while an operation is in flight. A request presented then starts no memory access and changes no memory content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rmw_mode | input | 1 | 0 = parity per lane, 1 = shared parity byte |
| cfg_odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_be | input | 4 | Lane enables, bit i = lane i (bits 8i+7:8i) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` on reads |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | 16 | Memory word address |
| mem_be | output | 5 | Bits 3:0 data lanes, bit 4 shared parity byte |
| mem_wdata | output | 32 | Memory write data |
| mem_wpar | output | 4 | Parity bit per lane |
| mem_rdata | input | 32 | Memory read data, one cycle after access |
| mem_rpar | input | 4 | Stored parity bits, one cycle after access |
| stat_clr | input | 4 | Write-one-to-clear mask for lanes 3:0 |
| stat_rdata | output | 16 | Status view, lane i in bit 8+i |
| par_err_pulse | output | 1 | One-cycle parity error indication |

## Verification
A wrong sequencer state shows at the memory port within one or two cycles. Possible symptoms are an extra read before a full write, a write-back with a partial enable, or a completion pulse at the wrong latency. A bad merge or a stale write-data register goes unnoticed at the write itself. It surfaces only when the word is read back, as wrong data, or as a parity error on a lane that was never corrupted. A corrupted sticky register is visible directly on `stat_rdata` in the following cycle. It stays visible until cleared, so a missed clear or a lost set persists across later clean reads.

// File: rtl/bpar_pkg.sv
// Shared constants, sequencer states and the parity function for the
// byte-lane parity guard. Assumes 8-bit lanes and a 16-bit status view.
package bpar_pkg;
    localparam int LANE_W   = 8;
    localparam int STAT_W   = 16;
    localparam int STAT_LSB = 8;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_DATA  = 2'd1,
        ST_MRG_DATA = 2'd2,
        ST_WRBACK   = 2'd3
    } seq_state_e;

    // Parity bit for one lane: XOR of the byte, inverted for odd polarity.
    function automatic logic lane_parity(input logic [LANE_W-1:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction
endpackage

// File: rtl/bpar_gen.sv
// Parity generator: one parity bit per lane of a data word.
// Assumes the polarity input is stable while the result is used.
module bpar_gen
    import bpar_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic                    odd,
    output logic [LANES-1:0]        par
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane parity bit.
        assign par[g] = lane_parity(data[g*LANE_W +: LANE_W], odd);
    end
endmodule

// File: rtl/bpar_check.sv
// Parity checker: recomputes lane parity on returned data and flags
// lanes whose stored bit disagrees, limited to the lanes in the mask.
module bpar_check
    import bpar_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*LANE_W-1:0] data,
    input  logic [LANES-1:0]        par_in,
    input  logic                    odd,
    input  logic [LANES-1:0]        mask,
    output logic [LANES-1:0]        err_vec
);
    logic [LANES-1:0] par_exp;

    bpar_gen #(.LANES(LANES)) u_regen (
        .data (data),
        .odd  (odd),
        .par  (par_exp)
    );

    // Mismatch per lane, dropped for lanes not being checked.
    assign err_vec = (par_exp ^ par_in) & mask;
endmodule

// File: rtl/bpar_status.sv
// Sticky per-lane error record with write-one-to-clear and a one-cycle
// error pulse. Assumes checks never occur in two consecutive cycles.
module bpar_status #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [LANES-1:0] err_vec,
    input  logic [LANES-1:0] clr_bits,
    output logic [LANES-1:0] sticky_q,
    output logic             err_pulse
);
    // Clear requested bits, then OR in new errors so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q  <= '0;
            err_pulse <= 1'b0;
        end else begin
            sticky_q  <= (sticky_q & ~clr_bits) | (chk_valid ? err_vec : '0);
            err_pulse <= chk_valid && (err_vec != '0);
        end
    end

    // R9: a pulse is always accompanied by a recorded lane.
    p_pulse_has_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (sticky_q != '0));

    // R9: the pulse lasts exactly one cycle.
    p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R8: a set bit not being cleared keeps the record non-empty.
    p_hold_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q & ~clr_bits) != '0) |=> (sticky_q != '0));
endmodule

// File: rtl/bpar_seq.sv
// Access sequencer: turns requests into memory accesses. Single accesses
// for reads, lane-mode writes and full writes; read, merge and
// write-back for partial writes in shared-parity mode. Assumes memory
// returns read data one cycle after the access.
module bpar_seq
    import bpar_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_rmw,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES-1:0]        req_be,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES:0]          mem_be,
    output logic [LANES*LANE_W-1:0] wr_data,
    input  logic [LANES*LANE_W-1:0] mem_rdata,
    output logic                    chk_valid,
    output logic [LANES-1:0]        chk_mask
);
    localparam int               DATA_W    = LANES * LANE_W;
    localparam logic [LANES-1:0] ALL_LANES = '1;
    localparam logic [LANES:0]   ALL_BE    = '1;

    seq_state_e        state_q, state_d;
    logic [LANES-1:0]  be_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] merged;
    logic              accept;
    logic              full_be;
    logic              single_wr;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign full_be   = (req_be == ALL_LANES);
    assign single_wr = req_write && (!cfg_rmw || full_be);
    assign req_ready = (state_q == ST_IDLE);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        // Enabled lanes take new data, the rest keep the read data.
        assign merged[g*LANE_W +: LANE_W] = be_q[g] ? wdata_q[g*LANE_W +: LANE_W]
                                                    : mem_rdata[g*LANE_W +: LANE_W];
    end

    // Next-state selection for the access sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (single_wr)      state_d = ST_IDLE;
                    else if (req_write) state_d = ST_MRG_DATA;
                    else                state_d = ST_RD_DATA;
                end
            end
            ST_RD_DATA:  state_d = ST_IDLE;
            ST_MRG_DATA: state_d = ST_WRBACK;
            ST_WRBACK:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Memory command and check window for the current state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_be    = '0;
        wr_data   = '0;
        chk_valid = 1'b0;
        chk_mask  = '0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    mem_en   = 1'b1;
                    mem_addr = req_addr;
                    if (single_wr) begin
                        mem_we  = 1'b1;
                        mem_be  = {cfg_rmw, req_be};
                        wr_data = req_wdata;
                    end else if (req_write) begin
                        mem_be = ALL_BE;
                    end else begin
                        mem_be = {cfg_rmw, req_be};
                    end
                end
            end
            ST_RD_DATA: begin
                chk_valid = 1'b1;
                chk_mask  = be_q;
            end
            ST_MRG_DATA: begin
                chk_valid = 1'b1;
                chk_mask  = ALL_LANES;
            end
            ST_WRBACK: begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                mem_be  = ALL_BE;
                wr_data = wdata_q;
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture on acceptance; merged word captured in the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end else if (state_q == ST_MRG_DATA) begin
            wdata_q <= merged;
        end
    end

    // Completion pulse and read data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (accept && single_wr) || (state_q == ST_RD_DATA)
                         || (state_q == ST_WRBACK);
            rsp_rdata <= (state_q == ST_RD_DATA) ? mem_rdata : '0;
        end
    end

    // R3: a full write in either mode needs no second cycle.
    p_full_write_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid && req_write && full_be) |=> (state_q == ST_IDLE));

    // R4: the merge cycle is always followed by a full-width write-back.
    p_merge_then_wrback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MRG_DATA) |=> (mem_en && mem_we && mem_be == ALL_BE));

    // R12: completion is only reported once the block is idle again.
    p_rsp_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);
endmodule

// File: rtl/bytelane_parity_unit.sv
// Top of the byte-lane parity guard: sequencer, write parity generator,
// read checker and sticky status. Assumes a memory with one-cycle
// read latency and a 16-bit status view with the lane field at bit 8.
module bytelane_parity_unit
    import bpar_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_rmw_mode,
    input  logic                    cfg_odd_par,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES-1:0]        req_be,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [LANES:0]          mem_be,
    output logic [LANES*LANE_W-1:0] mem_wdata,
    output logic [LANES-1:0]        mem_wpar,
    input  logic [LANES*LANE_W-1:0] mem_rdata,
    input  logic [LANES-1:0]        mem_rpar,
    input  logic [LANES-1:0]        stat_clr,
    output logic [STAT_W-1:0]       stat_rdata,
    output logic                    par_err_pulse
);
    logic             chk_valid;
    logic [LANES-1:0] chk_mask;
    logic [LANES-1:0] err_vec;
    logic [LANES-1:0] sticky;

    bpar_seq #(.LANES(LANES), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rmw   (cfg_rmw_mode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .wr_data   (mem_wdata),
        .mem_rdata (mem_rdata),
        .chk_valid (chk_valid),
        .chk_mask  (chk_mask)
    );

    bpar_gen #(.LANES(LANES)) u_wgen (
        .data (mem_wdata),
        .odd  (cfg_odd_par),
        .par  (mem_wpar)
    );

    bpar_check #(.LANES(LANES)) u_chk (
        .data    (mem_rdata),
        .par_in  (mem_rpar),
        .odd     (cfg_odd_par),
        .mask    (chk_mask),
        .err_vec (err_vec)
    );

    bpar_status #(.LANES(LANES)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .err_vec   (err_vec),
        .clr_bits  (stat_clr),
        .sticky_q  (sticky),
        .err_pulse (par_err_pulse)
    );

    // Place the lane field in the status view; all other bits read zero.
    always_comb begin
        stat_rdata = '0;
        stat_rdata[STAT_LSB +: LANES] = sticky;
    end

    // R5: a checked read always produces a completion one cycle later.
    p_check_then_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !mem_en && chk_mask != '0 && !$past(req_write)) |=> rsp_valid);
endmodule

// File: tb/sim_bytelane_parity_unit.sv
`timescale 1ns/100ps
module sim_bytelane_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rmw_mode = 1'b0, cfg_odd_par = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mem_en, mem_we, par_err_pulse;
    logic [31:0] rsp_rdata, mem_wdata;
    logic [15:0] mem_addr, stat_rdata;
    logic [4:0]  mem_be;
    logic [3:0]  mem_wpar;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_rpar = '0;
    logic [3:0]  stat_clr = '0;

    always #2.5 clk = ~clk;

    bytelane_parity_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rmw_mode(cfg_rmw_mode), .cfg_odd_par(cfg_odd_par),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_wpar(mem_wpar),
        .mem_rdata(mem_rdata), .mem_rpar(mem_rpar), .stat_clr(stat_clr),
        .stat_rdata(stat_rdata), .par_err_pulse(par_err_pulse)
    );

    // Memory model: 16 words, one-cycle read latency, preload port.
    logic [31:0] mem_d [16];
    logic [3:0]  mem_p [16];
    logic        pre_we = 1'b0;
    logic [3:0]  pre_a = '0;
    logic [31:0] pre_d = '0;
    logic [3:0]  pre_p = '0;
    int          wr_cnt = 0, rd_cnt = 0;
    logic [4:0]  last_wbe = '0, last_rbe = '0;
    logic [31:0] last_wd = '0;
    logic [3:0]  last_wp = '0;
    logic [31:0] nd;
    logic [3:0]  np;

    always @(posedge clk) begin
        if (pre_we) begin
            mem_d[pre_a] <= pre_d;
            mem_p[pre_a] <= pre_p;
        end else if (mem_en) begin
            if (mem_we) begin
                wr_cnt   <= wr_cnt + 1;
                last_wbe <= mem_be;
                last_wd  <= mem_wdata;
                last_wp  <= mem_wpar;
                nd = mem_d[mem_addr[3:0]];
                np = mem_p[mem_addr[3:0]];
                for (int i = 0; i < 4; i++) begin
                    if (mem_be[i]) nd[8*i +: 8] = mem_wdata[8*i +: 8];
                    if (mem_be[4] || mem_be[i]) np[i] = mem_wpar[i];
                end
                mem_d[mem_addr[3:0]] <= nd;
                mem_p[mem_addr[3:0]] <= np;
            end else begin
                rd_cnt   <= rd_cnt + 1;
                last_rbe <= mem_be;
            end
            mem_rdata <= mem_d[mem_addr[3:0]];
            mem_rpar  <= mem_p[mem_addr[3:0]];
        end
    end

    // Error pulse monitor.
    int          pulse_cnt = 0;
    logic [15:0] pulse_stat = '0;
    always @(negedge clk) begin
        if (rst_n && par_err_pulse) begin
            pulse_cnt  <= pulse_cnt + 1;
            pulse_stat <= stat_rdata;
        end
    end

    int tests = 0, fails = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] parvec(input logic [31:0] w, input logic odd);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (^w[8*i +: 8]) ^ odd;
        return p;
    endfunction

    function automatic logic [31:0] lanemask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    task automatic preload(input logic [3:0] a, input logic [31:0] d, input logic [3:0] p);
        @(negedge clk);
        pre_we = 1'b1; pre_a = a; pre_d = d; pre_p = p;
        @(posedge clk); #1 pre_we = 1'b0;
    endtask

    task automatic do_op(input logic wr, input logic [3:0] be, input logic [15:0] a,
                         input logic [31:0] d, output int lat, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
        @(posedge clk); #1 req_valid = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 10);
        rd = rsp_rdata;
        #1;
    endtask

    task automatic clr(input logic [3:0] m);
        @(negedge clk); stat_clr = m;
        @(posedge clk); #1 stat_clr = '0;
    endtask

    // {shared mode, odd, be, write data}
    localparam logic [37:0] VEC [8] = '{
        {1'b0, 1'b0, 4'hF, 32'h12345678},
        {1'b0, 1'b1, 4'hF, 32'hDEADBEEF},
        {1'b0, 1'b0, 4'h5, 32'hCAFEF00D},
        {1'b0, 1'b1, 4'hA, 32'h00FF0F01},
        {1'b1, 1'b0, 4'hF, 32'h80000001},
        {1'b1, 1'b1, 4'hF, 32'h7E7E7E7E},
        {1'b1, 1'b0, 4'h3, 32'h13572468},
        {1'b1, 1'b1, 4'hC, 32'hFFFFFFFF}
    };

    // Watchdog: reports the hang as a failed check and ends the run.
    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        int lat;
        logic [31:0] rd;
        int w0, r0, p0;
        // R11: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "req_ready", {31'b0, req_ready}, 32'd1);
        chk("R11", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R11", "err pulse", {31'b0, par_err_pulse}, 32'd0);
        chk("R11", "status", {16'b0, stat_rdata}, 32'd0);
        chk("R11", "mem_en", {31'b0, mem_en}, 32'd0);
        rst_n = 1'b1;

        // Vector table: write then read back, lane and shared modes.
        for (int i = 0; i < 8; i++) begin
            logic rmw, odd, partial;
            logic [3:0] be, a;
            logic [31:0] d, old, exp;
            {rmw, odd, be, d} = VEC[i];
            a = 4'(8 + i);
            partial = rmw && (be != 4'hF);
            @(negedge clk); cfg_rmw_mode = rmw; cfg_odd_par = odd;
            old = 32'h6B3C19E2 ^ (32'h01010101 * i);
            preload(a, old, parvec(old, odd));
            exp = (d & lanemask(be)) | (old & ~lanemask(be));
            w0 = wr_cnt; r0 = rd_cnt; p0 = pulse_cnt;
            do_op(1'b1, be, {12'b0, a}, d, lat, rd);
            chk(partial ? "R4" : (rmw ? "R3" : "R1"), "write latency", lat, partial ? 3 : 1);
            chk("R3", "reads during write", rd_cnt - r0, partial ? 1 : 0);
            chk("R1", "write accesses", wr_cnt - w0, 1);
            chk(rmw ? "R4" : "R1", "write enables", {27'b0, last_wbe}, rmw ? 32'h1F : {28'b0, be});
            if (rmw) begin
                chk("R4", "write data", last_wd, exp);
                chk("R2", "write parity", {28'b0, last_wp}, {28'b0, parvec(exp, odd)});
            end else begin
                chk("R1", "write data", last_wd & lanemask(be), d & lanemask(be));
                chk("R2", "write parity", {28'b0, last_wp & be}, {28'b0, parvec(d, odd) & be});
            end
            do_op(1'b0, 4'hF, {12'b0, a}, 32'h0, lat, rd);
            chk("R5", "read latency", lat, 2);
            chk("R5", "read data", rd, exp);
            chk("R5", "read enables", {27'b0, last_rbe}, {27'b0, rmw, 4'hF});
            chk("R6", "no error on clean word", pulse_cnt - p0, 0);
        end
        chk("R6", "status after clean traffic", {16'b0, stat_rdata}, 32'd0);

        // R6 R9 R10: corrupted lane 2 in lane mode, even parity.
        @(negedge clk); cfg_rmw_mode = 1'b0; cfg_odd_par = 1'b0;
        preload(4'd3, 32'h0F1E2D3C, parvec(32'h0F1E2D3C, 1'b0) ^ 4'b0100);
        p0 = pulse_cnt;
        do_op(1'b0, 4'hF, 16'd3, 32'h0, lat, rd);
        chk("R5", "read latency err", lat, 2);
        chk("R9", "one pulse", pulse_cnt - p0, 1);
        chk("R9", "status with pulse", {16'b0, pulse_stat}, 32'h0400);
        chk("R10", "status lane 2 at bit 10", {16'b0, stat_rdata}, 32'h0400);

        // R7: bad lane 1, not requested.
        preload(4'd4, 32'hA1B2C3D4, parvec(32'hA1B2C3D4, 1'b0) ^ 4'b0010);
        p0 = pulse_cnt;
        do_op(1'b0, 4'b0001, 16'd4, 32'h0, lat, rd);
        chk("R7", "no pulse unrequested", pulse_cnt - p0, 0);
        chk("R7", "status unchanged", {16'b0, stat_rdata}, 32'h0400);
        do_op(1'b0, 4'b0010, 16'd4, 32'h0, lat, rd);
        chk("R6", "lane 1 added", {16'b0, stat_rdata}, 32'h0600);

        // R8: sticky and write-one-to-clear.
        clr(4'b1000);
        chk("R8", "clear unset bit", {16'b0, stat_rdata}, 32'h0600);
        clr(4'b0010);
        chk("R8", "clear lane 1", {16'b0, stat_rdata}, 32'h0400);
        do_op(1'b0, 4'hF, 16'd8, 32'h0, lat, rd);
        chk("R8", "sticky over clean read", {16'b0, stat_rdata}, 32'h0400);

        // R8: set and clear on the same bit in the same cycle.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_be = 4'hF; req_addr = 16'd3;
        @(posedge clk); #1 req_valid = 1'b0; stat_clr = 4'b0100;
        @(posedge clk); #1 stat_clr = '0;
        @(negedge clk);
        chk("R8", "set wins over clear", {16'b0, stat_rdata}, 32'h0400);
        clr(4'b0100);
        chk("R8", "cleared", {16'b0, stat_rdata}, 32'h0);

        // R4 R6: shared mode partial write with read-phase error on lane 3.
        @(negedge clk); cfg_rmw_mode = 1'b1; cfg_odd_par = 1'b1;
        preload(4'd5, 32'h11223344, parvec(32'h11223344, 1'b1) ^ 4'b1000);
        p0 = pulse_cnt; w0 = wr_cnt; r0 = rd_cnt;
        do_op(1'b1, 4'b0001, 16'd5, 32'h000000AB, lat, rd);
        chk("R4", "rmw latency", lat, 3);
        chk("R4", "rmw reads", rd_cnt - r0, 1);
        chk("R4", "rmw writes", wr_cnt - w0, 1);
        chk("R6", "read-phase pulse", pulse_cnt - p0, 1);
        chk("R6", "read-phase status lane 3", {16'b0, stat_rdata}, 32'h0800);
        chk("R4", "merged data", last_wd, 32'h112233AB);
        chk("R4", "recomputed parity", {28'b0, last_wp}, {28'b0, parvec(32'h112233AB, 1'b1)});
        p0 = pulse_cnt;
        do_op(1'b0, 4'hF, 16'd5, 32'h0, lat, rd);
        chk("R4", "read back merged", rd, 32'h112233AB);
        chk("R4", "merged word clean", pulse_cnt - p0, 0);

        // R12: request held while busy is ignored.
        preload(4'd6, 32'h55AA55AA, parvec(32'h55AA55AA, 1'b1));
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_be = 4'hF; req_addr = 16'd8;
        @(posedge clk); #1
        req_write = 1'b1; req_addr = 16'd6; req_wdata = 32'h99999999;
        @(negedge clk);
        chk("R12", "ready low when busy", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk("R12", "read completes", {31'b0, rsp_valid}, 32'd1);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12", "no write while busy", wr_cnt - w0, 0);
        chk("R12", "memory untouched", mem_d[6], 32'h55AA55AA);

        // R11: reset clears the sticky record.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "status after reset", {16'b0, stat_rdata}, 32'd0);
        chk("R11", "ready after reset", {31'b0, req_ready}, 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule